// File: doc/BRIEF.md
# Time-Slot Scheduled Crossbar Switch

This block connects N word-wide input ports to N word-wide output ports through a crossbar. The switch settings are not derived from packet headers and no arbitration takes place. A connection schedule, worked out before the system runs, is held in a slot table. A free-running slot counter steps through that table. For every slot and every output, the entry either names the input that drives the output during that slot or marks the output idle. No output can have two drivers, so contention cannot occur, and every connection has a known, fixed timing.

The table is written through a small load port. Writes take effect only while the switch is disabled or held in reset. Once the enable is raised, the counter starts at slot 0 and advances by one slot per clock, wrapping after the last slot. Each output word passes through exactly one register stage. An output whose current entry is idle, or whose chosen input carries no valid word, presents zero with its valid flag low.

Top module: `tdm_xbar`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, every `out_valid` bit is 0 and every `out_data` word is 0.
- R2: While `en` is low, every output presents zero data with valid low from the next clock edge onward, whatever the inputs carry.
- R3: The first enabled clock edge uses slot 0. Each further enabled edge uses the next slot, and slot DEPTH-1 is followed by slot 0.
- R4: If the entry for slot s and output o is active (`cfg_on`=1) and names input i (`cfg_src`=i), the edge that uses slot s loads `in_data` word i into output word o, with `out_valid[o]`=`in_valid[i]`. The result is visible exactly one cycle later.
- R5: If the entry for slot s and output o is inactive (`cfg_on`=0), output o presents zero with valid low after the edge that uses slot s, whatever the inputs carry.
- R6: If an active entry selects an input whose `in_valid` bit is low, the output shows data 0 and valid low.
- R7: A write (`cfg_we`=1) to entry (`cfg_slot`, `cfg_port`) is stored only while `en` is low or reset is asserted. A write made while enabled leaves the table unchanged. Port words are packed with word k at bits [k*W +: W].
- R8: Several outputs may name the same input in the same slot, and each of them then receives that input's word.
- R9: Table contents persist across disable periods. Every new rise of `en` restarts the schedule at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (does not clear the table) |
| en | input | 1 | Run enable; low holds slot 0 and blanks outputs |
| in_data | input | N*W | Input words, word k at [k*W +: W] |
| in_valid | input | N | Per-input word valid |
| out_data | output | N*W | Registered output words |
| out_valid | output | N | Registered per-output valid |
| cfg_we | input | 1 | Table write strobe |
| cfg_slot | input | SW | Slot index of the entry written |
| cfg_port | input | PW | Output index of the entry written |
| cfg_src | input | PW | Input index stored in the entry |
| cfg_on | input | 1 | Entry active flag |

## Verification
The bench uses 4 ports and a 5-slot table, so the non-power-of-two wrap is exercised. Every output is compared on every cycle against a slot/table model kept in the bench. The first table mixes idle entries with varied sources, and the inputs carry counter-derived words whose valid bits toggle with a period of three. This separates a wrong source from a wrong slot phase, and an idle entry from a missing input valid. A second table routes one input to all outputs in each slot, which checks multicast. Writes issued while running, a disable period and re-enabling then show that the write lockout holds, that the table persists and that the schedule restarts at slot 0.

// File: rtl/tdm_xbar_pkg.sv
package tdm_xbar_pkg;

  // Slot following cur in a table of depth entries.
  function automatic int unsigned slot_after(input int unsigned cur, input int unsigned depth);
    if (cur + 1 >= depth) return 0;
    return cur + 1;
  endfunction

  // Flat storage index of the entry for (slot, port).
  function automatic int unsigned entry_index(input int unsigned slot, input int unsigned port,
                                              input int unsigned nports);
    return slot * nports + port;
  endfunction

  // Index width that can hold values 0..count-1 (at least one bit).
  function automatic int unsigned idx_bits(input int unsigned count);
    return (count > 1) ? $clog2(count) : 1;
  endfunction

endpackage

// File: rtl/tdm_slot_ctr.sv
module tdm_slot_ctr #(
  parameter int unsigned DEPTH = 5,
  parameter int unsigned SW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  output logic [SW-1:0] slot_q
);
  import tdm_xbar_pkg::*;

  localparam logic [SW-1:0] LAST = SW'(DEPTH - 1);

  logic [SW-1:0] slot_nx;
  logic          wrap_evt;

  always_comb begin
    slot_nx  = SW'(slot_after(int'(slot_q), DEPTH));
    wrap_evt = en && (slot_q == LAST);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   slot_q <= '0;
    else if (!en) slot_q <= '0;
    else          slot_q <= slot_nx;
  end

  // R3: one slot per enabled cycle, wrap after the last slot
  p_slot_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wrap_evt) |=> (slot_q == $past(slot_q) + 1'b1));
  p_slot_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (slot_q == '0));
  // R9: a new enable always starts from slot 0
  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |-> (slot_q == '0));
endmodule

// File: rtl/tdm_slot_table.sv
module tdm_slot_table #(
  parameter int unsigned N     = 4,
  parameter int unsigned DEPTH = 5,
  parameter int unsigned SW    = 3,
  parameter int unsigned PW    = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            locked,
  input  logic            wr_req,
  input  logic [SW-1:0]   wr_slot,
  input  logic [PW-1:0]   wr_port,
  input  logic [PW-1:0]   wr_src,
  input  logic            wr_on,
  input  logic [SW-1:0]   rd_slot,
  output logic [N-1:0]    rd_on,
  output logic [N*PW-1:0] rd_src
);
  import tdm_xbar_pkg::*;

  localparam int unsigned ENTRIES = DEPTH * N;
  localparam int unsigned EW      = idx_bits(ENTRIES);

  logic [ENTRIES-1:0] ent_on;
  logic [PW-1:0]      ent_src [ENTRIES];

  logic          wr_in_range;
  logic [EW-1:0] widx;
  logic          wr_take;
  logic          wr_blocked;

  always_comb begin
    wr_in_range = (int'(wr_slot) < DEPTH) && (int'(wr_port) < N);
    widx        = EW'(entry_index(int'(wr_slot), int'(wr_port), N));
    wr_take     = wr_req && wr_in_range && !locked;
    wr_blocked  = wr_req && wr_in_range && locked;
  end

  // Table contents survive reset on purpose so they can be loaded during it.
  always_ff @(posedge clk) begin
    if (wr_take) begin
      ent_on[widx]  <= wr_on;
      ent_src[widx] <= wr_src;
    end
  end

  for (genvar o = 0; o < N; o++) begin : g_rd
    logic [EW-1:0] ridx;
    always_comb begin
      ridx                  = EW'(entry_index(int'(rd_slot), o, N));
      rd_on[o]              = ent_on[ridx];
      rd_src[o*PW +: PW]    = ent_src[ridx];
    end
  end

  // R7: writes while running leave the addressed entry untouched
  p_write_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_blocked |=> (ent_on[$past(widx)] == $past(ent_on[widx])) &&
                   (ent_src[$past(widx)] == $past(ent_src[widx])));
endmodule

// File: rtl/tdm_out_lane.sv
module tdm_out_lane #(
  parameter int unsigned N  = 4,
  parameter int unsigned W  = 16,
  parameter int unsigned PW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic [N*W-1:0] in_data,
  input  logic [N-1:0]   in_valid,
  input  logic           sel_on,
  input  logic [PW-1:0]  sel_src,
  output logic [W-1:0]   lane_data,
  output logic           lane_valid
);
  logic         src_ok;
  logic [W-1:0] pick_word;
  logic         pick_vld;
  logic         pass;

  always_comb begin
    src_ok    = int'(sel_src) < N;
    pick_word = '0;
    pick_vld  = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (int'(sel_src) == i) begin
        pick_word = in_data[i*W +: W];
        pick_vld  = in_valid[i];
      end
    end
    pass = en && sel_on && src_ok && pick_vld;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lane_valid <= 1'b0;
      lane_data  <= '0;
    end else begin
      lane_valid <= pass;
      lane_data  <= pass ? pick_word : '0;
    end
  end

  // R5/R6: a lane without a valid word carries zero
  p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !lane_valid |-> (lane_data == '0));
  // R2: disabled switch blanks the lane at the next edge
  p_off_blank_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !lane_valid);
  // R4: a valid lane never outlives an idle entry
  p_idle_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_on |=> !lane_valid);
endmodule

// File: rtl/tdm_xbar.sv
module tdm_xbar #(
  parameter int unsigned N     = 4,
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 5,
  parameter int unsigned SW    = tdm_xbar_pkg::idx_bits(DEPTH),
  parameter int unsigned PW    = tdm_xbar_pkg::idx_bits(N)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic [N*W-1:0] in_data,
  input  logic [N-1:0]   in_valid,
  output logic [N*W-1:0] out_data,
  output logic [N-1:0]   out_valid,
  input  logic           cfg_we,
  input  logic [SW-1:0]  cfg_slot,
  input  logic [PW-1:0]  cfg_port,
  input  logic [PW-1:0]  cfg_src,
  input  logic           cfg_on
);
  logic [SW-1:0]   slot_q;
  logic            tbl_locked;
  logic [N-1:0]    cur_on;
  logic [N*PW-1:0] cur_src;

  assign tbl_locked = en && rst_n;

  tdm_slot_ctr #(.DEPTH(DEPTH), .SW(SW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .en(en), .slot_q(slot_q)
  );

  tdm_slot_table #(.N(N), .DEPTH(DEPTH), .SW(SW), .PW(PW)) u_tbl (
    .clk(clk), .rst_n(rst_n), .locked(tbl_locked),
    .wr_req(cfg_we), .wr_slot(cfg_slot), .wr_port(cfg_port),
    .wr_src(cfg_src), .wr_on(cfg_on),
    .rd_slot(slot_q), .rd_on(cur_on), .rd_src(cur_src)
  );

  for (genvar o = 0; o < N; o++) begin : g_lane
    tdm_out_lane #(.N(N), .W(W), .PW(PW)) u_lane (
      .clk(clk), .rst_n(rst_n), .en(en),
      .in_data(in_data), .in_valid(in_valid),
      .sel_on(cur_on[o]), .sel_src(cur_src[o*PW +: PW]),
      .lane_data(out_data[o*W +: W]), .lane_valid(out_valid[o])
    );
  end

  // R1: first cycle after reset shows nothing
  p_reset_quiet_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (out_valid == '0));
endmodule

// File: tb/sim_tdm_xbar.sv
`timescale 1ns/1ps
module sim_tdm_xbar;
  localparam int N = 4;
  localparam int W = 16;
  localparam int D = 5;
  localparam int SW = 3;
  localparam int PW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [N*W-1:0] in_data = '0;
  logic [N-1:0] in_valid = '0;
  logic [N*W-1:0] out_data;
  logic [N-1:0] out_valid;
  logic cfg_we = 1'b0;
  logic [SW-1:0] cfg_slot = '0;
  logic [PW-1:0] cfg_port = '0;
  logic [PW-1:0] cfg_src = '0;
  logic cfg_on = 1'b0;

  always #2.5 clk = ~clk;

  tdm_xbar #(.N(N), .W(W), .DEPTH(D)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .in_data(in_data), .in_valid(in_valid),
    .out_data(out_data), .out_valid(out_valid), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
    .cfg_port(cfg_port), .cfg_src(cfg_src), .cfg_on(cfg_on)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int m_slot = 0;
  bit m_on [D][N];
  int m_src [D][N];
  string phase = "init";
  bit finished = 1'b0;

  function automatic logic [W-1:0] word_of(int c, int i);
    return W'((i + 1) * 4660 + c * 37);
  endfunction

  function automatic bit vld_of(int c, int i);
    return ((c + i) % 3) != 0;
  endfunction

  // One clock: drive inputs, predict, clock, compare. Starts and ends at negedge.
  task automatic step();
    logic [W-1:0] exp_d [N];
    bit exp_v [N];
    string tag [N];
    for (int i = 0; i < N; i++) begin
      in_data[i*W +: W] = word_of(cyc, i);
      in_valid[i] = vld_of(cyc, i);
    end
    for (int o = 0; o < N; o++) begin
      exp_d[o] = '0; exp_v[o] = 1'b0;
      if (!rst_n) tag[o] = "R1";
      else if (!en) tag[o] = "R2";
      else if (!m_on[m_slot][o]) tag[o] = "R5";
      else if (!vld_of(cyc, m_src[m_slot][o])) tag[o] = "R6";
      else begin
        tag[o] = "R4";
        exp_v[o] = 1'b1;
        exp_d[o] = word_of(cyc, m_src[m_slot][o]);
      end
    end
    @(posedge clk);
    if (rst_n && en) m_slot = (m_slot + 1) % D; else m_slot = 0;
    cyc++;
    @(negedge clk);
    for (int o = 0; o < N; o++) begin
      n_cmp++;
      if (out_valid[o] !== exp_v[o] || out_data[o*W +: W] !== exp_d[o]) begin
        n_bad++;
        $display("FAIL %s/%s out%0d cyc %0d: got v=%0b d=%h exp v=%0b d=%h",
                 phase, tag[o], o, cyc, out_valid[o], out_data[o*W +: W], exp_v[o], exp_d[o]);
      end
    end
  endtask

  // Write one entry during a step; model follows only if the switch is unlocked.
  task automatic put(int s, int o, int src, bit on);
    cfg_we = 1'b1; cfg_slot = SW'(s); cfg_port = PW'(o); cfg_src = PW'(src); cfg_on = on;
    if (!(en && rst_n)) begin m_on[s][o] = on; m_src[s][o] = src; end
    step();
    cfg_we = 1'b0;
  endtask

  initial begin
    #200000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1 and R7: load table A while held in reset, outputs quiet
    phase = "R1_R7_load_in_reset";
    for (int s = 0; s < D; s++)
      for (int o = 0; o < N; o++)
        put(s, o, (s * 3 + o) % N, ((s + o) % 4) != 3);
    rst_n = 1'b1;
    phase = "R1_after_release";
    step();
    // R2: disabled with live inputs
    phase = "R2_idle";
    for (int k = 0; k < 4; k++) step();
    // R3 R4 R5 R6: run through several table periods
    phase = "R3_run";
    en = 1'b1;
    for (int k = 0; k < 3 * D + 2; k++) step();
    // R7: writes while running must be ignored
    phase = "R7_locked_write";
    for (int s = 0; s < D; s++) put(s, s % N, (s + 1) % N, !m_on[s][s % N]);
    for (int k = 0; k < D + 1; k++) step();
    // R8: multicast table B loaded while disabled
    en = 1'b0;
    phase = "R8_load";
    for (int s = 0; s < D; s++)
      for (int o = 0; o < N; o++) put(s, o, s % N, 1'b1);
    phase = "R8_R9_multicast";
    en = 1'b1;
    for (int k = 0; k < 2 * D + 1; k++) step();
    // R9: disable mid-schedule, re-enable: table kept, slot 0 again
    en = 1'b0;
    phase = "R9_pause";
    for (int k = 0; k < 2; k++) step();
    en = 1'b1;
    phase = "R9_restart";
    for (int k = 0; k < D + 3; k++) step();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule